// File: doc/BRIEF.md
# Shadow Store/Recall Sequencer

This controller moves data between a volatile working array and its nonvolatile shadow copy. It takes four kinds of trigger. A software store request and a software recall request come from an external command decoder. A supply-below-switch-level flag comes from an external comparator, and so does a supply-below-reset-level flag. While a transfer runs, the controller holds host reads and writes off the array. It also raises one phase strobe at a time toward the array and the shadow, so the storage logic knows which step to perform.

A store runs in two steps. It first erases the old nonvolatile contents and then programs the shadow from the working array. A recall also runs in two steps. It first clears the working array and then loads the shadow contents into it; the shadow itself is not changed. Each step lasts a parameterised number of clock cycles. A dirty flag records whether an accepted host write has happened since the last transfer. When the supply sags, a store starts only if that flag is set, and it starts after a short grace window in which an access already under way may finish. A recall becomes pending after any drop below the reset level, including power-up. It runs once the supply is back above the switch level.

Top module: `nvx_xfer_ctrl`

## Requirements
- R1: A store asserts `erase_stb` for exactly ERASE_CYC cycles. `program_stb` follows in the very next cycle and stays high for exactly PROG_CYC cycles, after which the block returns to idle.
- R2: A recall asserts `clear_stb` for exactly CLEAR_CYC cycles. `transfer_stb` follows at once for exactly XFER_CYC cycles. Neither `erase_stb` nor `program_stb` is raised during a recall.
- R3: `busy` is high in every strobe cycle of a store or recall and low otherwise. While `busy` is high, `host_rd_ok` and `host_wr_ok` are 0. While it is low, each equals its request input.
- R4: `dirty` goes to 1 after a cycle with `host_wr_ok` = 1. It is 0 from the first cycle of any store or recall, and this includes a write accepted in the same cycle that the transfer starts.
- R5: While `pwr_fail` = 1 and `dirty` = 1 in idle, the block waits GRACE_CYC cycles with `busy` low and then runs a store. With `dirty` = 0, `pwr_fail` starts nothing.
- R6: A software store runs whether `dirty` is 0 or 1. It is ignored while `pwr_fail` = 1.
- R7: A cycle with `pwr_deep` = 1 latches a recall. Reset also latches one. The latched recall starts in the first idle cycle with `pwr_fail` = 0. A dip in which `pwr_fail` rises but `pwr_deep` stays 0 starts no recall.
- R8: When software store and software recall requests arrive in the same idle cycle, the store runs and the recall is dropped.
- R9: Software requests that arrive during a transfer or the grace window are dropped. A recall latched by `pwr_deep` during a transfer is kept and runs after it.
- R10: During and right after reset, `busy`, `dirty` and all four strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; latches a power-up recall |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| pwr_fail | input | 1 | Supply below switch level |
| pwr_deep | input | 1 | Supply below reset level |
| host_rd | input | 1 | Host read attempt |
| host_wr | input | 1 | Host write attempt |
| host_rd_ok | output | 1 | Read let through to the array |
| host_wr_ok | output | 1 | Write let through to the array |
| busy | output | 1 | Transfer in progress, host blocked |
| dirty | output | 1 | Array written since the last transfer |
| erase_stb | output | 1 | Shadow erase step active |
| program_stb | output | 1 | Shadow program step active |
| clear_stb | output | 1 | Working array clear step active |
| transfer_stb | output | 1 | Shadow-to-array load step active |

## Verification
An accepted host write can land in the same cycle that a transfer starts, so the set and clear of the dirty flag meet in one clock edge. The bench provokes this by raising `host_wr` together with `sw_store_req` in one idle cycle. It judges the result in three ways. `host_wr_ok` must be 1 in that cycle. `dirty` must be 0 through the store. No automatic store may follow when `pwr_fail` is then raised. A second collision case injects a store request and a deep dip into the middle of a recall: the store must be dropped and the recall must be repeated.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_GRACE,
      PH_ERASE,
      PH_PROG,
      PH_CLEAR,
      PH_XFER
   } nvx_phase_e;

   typedef enum logic [1:0] {
      ST_NONE,
      ST_STORE,
      ST_AUTO,
      ST_RECALL
   } nvx_start_e;

   function automatic int unsigned nvx_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned nvx_atleast1(input int unsigned a);
      return (a < 1) ? 1 : a;
   endfunction

endpackage

// File: rtl/nvx_phase_timer.sv
module nvx_phase_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // Phase lengths (R1, R2) rely on the count resting at zero once spent.
   assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

endmodule

// File: rtl/nvx_req_arbiter.sv
module nvx_req_arbiter
   import nvx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idle,
   input  logic       sw_store_req,
   input  logic       sw_recall_req,
   input  logic       pwr_fail,
   input  logic       pwr_deep,
   input  logic       host_wr_ok,
   input  logic       begin_store,
   input  logic       begin_recall,
   output nvx_start_e start,
   output logic       dirty,
   output logic       recall_pend
);

   // A deep dip always wins over the clear, so a latch in the start cycle survives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            recall_pend <= 1'b1;
      else if (pwr_deep)     recall_pend <= 1'b1;
      else if (begin_recall) recall_pend <= 1'b0;
   end

   // A write accepted in the start cycle is captured by that transfer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           dirty <= 1'b0;
      else if (begin_store || begin_recall) dirty <= 1'b0;
      else if (host_wr_ok)                  dirty <= 1'b1;
   end

   always_comb begin
      start = ST_NONE;
      if (idle) begin
         if (sw_store_req && !pwr_fail)                   start = ST_STORE;
         else if (pwr_fail && dirty)                      start = ST_AUTO;
         else if (sw_recall_req || (recall_pend && !pwr_fail)) start = ST_RECALL;
      end
   end

   assert_pend_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && recall_pend) |=> recall_pend);

   assert_deep_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_deep |=> recall_pend);

endmodule

// File: rtl/nvx_xfer_ctrl.sv
module nvx_xfer_ctrl
   import nvx_pkg::*;
#(
   parameter int unsigned ERASE_CYC = 12,
   parameter int unsigned PROG_CYC  = 20,
   parameter int unsigned CLEAR_CYC = 4,
   parameter int unsigned XFER_CYC  = 10,
   parameter int unsigned GRACE_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_store_req,
   input  logic sw_recall_req,
   input  logic pwr_fail,
   input  logic pwr_deep,
   input  logic host_rd,
   input  logic host_wr,
   output logic host_rd_ok,
   output logic host_wr_ok,
   output logic busy,
   output logic dirty,
   output logic erase_stb,
   output logic program_stb,
   output logic clear_stb,
   output logic transfer_stb
);

   localparam int unsigned ERASE_N = nvx_atleast1(ERASE_CYC);
   localparam int unsigned PROG_N  = nvx_atleast1(PROG_CYC);
   localparam int unsigned CLEAR_N = nvx_atleast1(CLEAR_CYC);
   localparam int unsigned XFER_N  = nvx_atleast1(XFER_CYC);
   localparam int unsigned MAX_N   = nvx_max2(nvx_max2(ERASE_N, PROG_N),
                                     nvx_max2(nvx_max2(CLEAR_N, XFER_N), GRACE_CYC));
   localparam int unsigned CNT_W   = $clog2(MAX_N + 1);

   localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_N - 1);
   localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_N - 1);
   localparam logic [CNT_W-1:0] CLEAR_LD = CNT_W'(CLEAR_N - 1);
   localparam logic [CNT_W-1:0] XFER_LD  = CNT_W'(XFER_N - 1);

   nvx_phase_e       state_q, state_d;
   nvx_phase_e       auto_phase;
   logic [CNT_W-1:0] auto_ld;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_done;
   logic             idle;
   logic             begin_store, begin_recall;
   logic             recall_pend;
   nvx_start_e       start;

   // Zero grace cycles drop the wait state entirely.
   generate
      if (GRACE_CYC > 0) begin : g_grace
         assign auto_phase = PH_GRACE;
         assign auto_ld    = CNT_W'(GRACE_CYC - 1);
      end else begin : g_nograce
         assign auto_phase = PH_ERASE;
         assign auto_ld    = ERASE_LD;
      end
   endgenerate

   assign idle = (state_q == PH_IDLE);
   assign busy = (state_q == PH_ERASE) || (state_q == PH_PROG) ||
                 (state_q == PH_CLEAR) || (state_q == PH_XFER);

   assign host_rd_ok = host_rd && !busy;
   assign host_wr_ok = host_wr && !busy;

   assign begin_store  = (state_d == PH_ERASE) && (state_q != PH_ERASE);
   assign begin_recall = (state_d == PH_CLEAR) && (state_q != PH_CLEAR);

   nvx_req_arbiter u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .idle          (idle),
      .sw_store_req  (sw_store_req),
      .sw_recall_req (sw_recall_req),
      .pwr_fail      (pwr_fail),
      .pwr_deep      (pwr_deep),
      .host_wr_ok    (host_wr_ok),
      .begin_store   (begin_store),
      .begin_recall  (begin_recall),
      .start         (start),
      .dirty         (dirty),
      .recall_pend   (recall_pend)
   );

   nvx_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         PH_IDLE: begin
            unique case (start)
               ST_STORE:  begin state_d = PH_ERASE;   tmr_load = 1'b1; tmr_val = ERASE_LD; end
               ST_AUTO:   begin state_d = auto_phase; tmr_load = 1'b1; tmr_val = auto_ld;  end
               ST_RECALL: begin state_d = PH_CLEAR;   tmr_load = 1'b1; tmr_val = CLEAR_LD; end
               default:   ;
            endcase
         end
         PH_GRACE: if (tmr_done) begin state_d = PH_ERASE; tmr_load = 1'b1; tmr_val = ERASE_LD; end
         PH_ERASE: if (tmr_done) begin state_d = PH_PROG;  tmr_load = 1'b1; tmr_val = PROG_LD;  end
         PH_PROG:  if (tmr_done) state_d = PH_IDLE;
         PH_CLEAR: if (tmr_done) begin state_d = PH_XFER;  tmr_load = 1'b1; tmr_val = XFER_LD;  end
         PH_XFER:  if (tmr_done) state_d = PH_IDLE;
         default:  state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PH_IDLE;
      else        state_q <= state_d;
   end

   assign erase_stb    = (state_q == PH_ERASE);
   assign program_stb  = (state_q == PH_PROG);
   assign clear_stb    = (state_q == PH_CLEAR);
   assign transfer_stb = (state_q == PH_XFER);

   assert_erase_then_prog_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(erase_stb) |-> program_stb);

   assert_clear_then_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clear_stb) |-> transfer_stb);

   assert_clean_in_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dirty);

   assert_grace_needs_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_GRACE) |-> dirty);

   assert_store_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(erase_stb) && $past(idle)) |->
         (($past(sw_store_req) && !$past(pwr_fail)) || $past(dirty)));

   assert_host_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(dirty) || !dirty));

endmodule

// File: tb/nvx_xfer_ctrl_test.sv
module nvx_xfer_ctrl_test;

   localparam int E = 12;
   localparam int P = 20;
   localparam int C = 4;
   localparam int X = 10;
   localparam int G = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_store_req = 0, sw_recall_req = 0, pwr_fail = 0, pwr_deep = 0;
   logic host_rd = 0, host_wr = 0;
   logic host_rd_ok, host_wr_ok, busy, dirty;
   logic erase_stb, program_stb, clear_stb, transfer_stb;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit model_dirty = 0;

   always #10 clk = ~clk;

   nvx_xfer_ctrl #(.ERASE_CYC(E), .PROG_CYC(P), .CLEAR_CYC(C), .XFER_CYC(X), .GRACE_CYC(G)) uut (
      .clk(clk), .rst_n(rst_n), .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
      .pwr_fail(pwr_fail), .pwr_deep(pwr_deep), .host_rd(host_rd), .host_wr(host_wr),
      .host_rd_ok(host_rd_ok), .host_wr_ok(host_wr_ok), .busy(busy), .dirty(dirty),
      .erase_stb(erase_stb), .program_stb(program_stb), .clear_stb(clear_stb),
      .transfer_stb(transfer_stb));

   function automatic int exp_ok(input bit req, input bit blocked);
      return (req && !blocked) ? 1 : 0;
   endfunction

   function automatic int strobes();
      return {28'd0, erase_stb, program_stb, clear_stb, transfer_stb};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_reqs();
      sw_store_req = 0; sw_recall_req = 0; pwr_deep = 0; host_rd = 0; host_wr = 0;
   endtask

   // Runs one phase of n cycles, probing host blocking each cycle.
   task automatic phase(input string tag, input int n, input int exp_strobes);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clear_reqs();
         chk({tag, " strobe"}, strobes(), exp_strobes);
         chk("R3 busy", busy, 1);
         host_wr = 1; host_rd = 1;
         #1;
         chk("R3 wr blocked", host_wr_ok, exp_ok(1, 1));
         chk("R3 rd blocked", host_rd_ok, exp_ok(1, 1));
      end
   endtask

   task automatic end_idle(input string tag);
      @(negedge clk);
      clear_reqs();
      chk({tag, " idle after"}, busy, 0);
      chk("R4 clean after transfer", dirty, 0);
      model_dirty = 0;
   endtask

   task automatic expect_store(input string tag);
      phase({tag, " R1 erase"}, E, 8);
      phase({tag, " R1 program"}, P, 4);
      end_idle(tag);
   endtask

   task automatic expect_recall(input string tag, input bit inject);
      for (int i = 0; i < C + X; i++) begin
         @(negedge clk);
         clear_reqs();
         if (inject && i == 2) pwr_fail = 0;
         chk({tag, " R2 strobe"}, strobes(), (i < C) ? 2 : 1);
         chk("R3 busy", busy, 1);
         host_wr = 1;
         if (inject && i == 1) begin sw_store_req = 1; pwr_deep = 1; pwr_fail = 1; end
         #1;
         chk("R3 wr blocked", host_wr_ok, 0);
      end
      end_idle(tag);
   endtask

   task automatic quiet(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sw_store_req = 0; sw_recall_req = 0; host_rd = 0; host_wr = 0;
         chk({tag, " busy low"}, busy, 0);
         chk({tag, " no strobe"}, strobes(), 0);
      end
   endtask

   task automatic do_write(input string tag);
      host_wr = 1;
      #1;
      chk({tag, " R3 wr ok"}, host_wr_ok, exp_ok(1, 0));
      @(negedge clk);
      host_wr = 0;
      model_dirty = 1;
      chk("R4 dirty set", dirty, int'(model_dirty));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1d5a_0c71));
      repeat (3) @(negedge clk);
      chk("R10 busy in reset", busy, 0);
      chk("R10 strobes in reset", strobes(), 0);
      chk("R10 dirty in reset", dirty, 0);
      rst_n = 1;
      chk("R10 busy after reset", busy, 0);
      // Power-up recall latched by reset.
      expect_recall("R7 power-up", 0);

      // Software store with a clean array.
      sw_store_req = 1;
      expect_store("R6 clean sw store");

      // Write, then software recall.
      do_write("R4");
      sw_recall_req = 1;
      expect_recall("R2 sw recall", 0);

      // Supply sag with clean array: nothing.
      pwr_fail = 1;
      quiet("R5 clean sag", 8);
      pwr_fail = 0;
      quiet("R7 shallow dip", 6);

      // Supply sag with dirty array: grace then store.
      do_write("R5");
      pwr_fail = 1;
      quiet("R5 grace", G);
      expect_store("R5 auto store");
      sw_store_req = 1;
      quiet("R6 sw store under fail", 4);
      pwr_fail = 0;
      quiet("R7 no recall after shallow", 4);

      // Deep dip while idle.
      pwr_fail = 1; pwr_deep = 1;
      quiet("R7 deep held", 1);
      pwr_deep = 0;
      quiet("R7 wait above reset", 3);
      pwr_fail = 0;
      expect_recall("R7 deep dip", 0);

      // Same-cycle store and recall requests.
      sw_store_req = 1; sw_recall_req = 1;
      expect_store("R8 priority");
      quiet("R8 recall dropped", 3);

      // Requests during a recall: store dropped, deep latch kept.
      sw_recall_req = 1;
      expect_recall("R9 first", 1);
      expect_recall("R9 relatched", 0);
      quiet("R9 store dropped", 3);

      // Write accepted in the same cycle a store starts.
      sw_store_req = 1; host_wr = 1;
      #1;
      chk("R4 start-cycle write ok", host_wr_ok, 1);
      expect_store("R4 collision");
      pwr_fail = 1;
      quiet("R4 no auto store after collision", 6);
      pwr_fail = 0;
      quiet("R4 settle", 1);

      // Random host traffic and software requests.
      for (int it = 0; it < 40; it++) begin
         int op;
         op = $urandom % 5;
         case (op)
            0: do_write("R4 rand");
            1: begin
               host_rd = 1;
               #1;
               chk("R3 rand rd ok", host_rd_ok, exp_ok(1, 0));
               @(negedge clk);
               host_rd = 0;
               chk("R4 rand dirty kept", dirty, int'(model_dirty));
            end
            2: begin sw_store_req = 1; expect_store("R1 rand"); end
            3: begin sw_recall_req = 1; expect_recall("R2 rand", 0); end
            default: begin
               @(negedge clk);
               chk("R4 rand idle dirty", dirty, int'(model_dirty));
            end
         endcase
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule